// File: doc/BRIEF.md
# Read Transaction Sequence Checker

This block watches a read handshake and confirms that every transaction follows the phase order. The order is request, then acknowledge, then a short gap, then completion, then a stream of data beats, then an end marker. It carries no data path. It only looks at five single-bit strobes and judges their order cycle by cycle. The first cycle that breaks the order produces a one-cycle error pulse and an error code naming the broken rule. A transaction that reaches its end marker legally produces a one-cycle completion pulse. In either case the checker goes back to idle and waits for the next request.

A two-bit mode input picks the timing variant. The variant is captured in the request cycle and holds for the whole transaction.
- Mode 0 keeps the phases separate.
- Mode 1 requires the first data beat to share its cycle with completion.
- Mode 2 also requires the end marker to share its cycle with the last data beat.

The block is meant to sit beside a read interface in simulation or in hardware, as a live protocol monitor.

Top module: `rdseq_checker`

## Requirements
- R1: While reset is high, and in the first cycle after it, err_o, err_code_o and cmplt_o are all zero.
- R2: ack_i must be high in the cycle directly after the request cycle. Otherwise the error code is 1 (missing acknowledge).
- R3: Count gap cycles from the cycle after the acknowledge. done_i is accepted only 2 to 5 cycles after the acknowledge. done_i in the first cycle after the acknowledge has no effect. If done_i has not been accepted by the fifth cycle, that cycle raises code 2 (timeout).
- R4: With separate phases, beat and end-marker inputs in the done cycle are ignored. After that, each cycle carries either a beat (beat_i) or the end marker (last_i). The end marker completes the transaction. A cycle with neither raises code 4 (beat gap). Zero beats are legal.
- R5: In modes 1 and 2, the done cycle must also carry a beat. Otherwise it raises code 3 (done without beat).
- R6: In mode 2, the end marker must share its cycle with a beat. An end marker without a beat raises code 5. A done cycle that carries both a beat and the end marker completes the transaction at once.
- R7: A request in any cycle after the request cycle, up to and including the end-marker cycle, raises code 6 (overlap). The transaction is abandoned and that request does not start a new one.
- R8: In idle, only req_i is observed. After an error or a completion the checker is idle, so a request in the very next cycle is accepted.
- R9: The mode is captured in the request cycle. Later changes of mode_i have no effect on that transaction. Mode value 3 behaves as mode 0.
- R10: Each event is reported in the cycle after the offending or completing input cycle, as a single-cycle pulse. err_code_o is 0 whenever err_o is low. err_o and cmplt_o are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Read request strobe |
| ack_i | input | 1 | Acknowledge strobe |
| done_i | input | 1 | Completion strobe |
| beat_i | input | 1 | Data beat valid |
| last_i | input | 1 | End-of-transfer marker |
| mode_i | input | 2 | Timing variant: 0 separate, 1 done with first beat, 2 also end with last beat, 3 as 0 |
| err_o | output | 1 | One-cycle protocol error pulse |
| err_code_o | output | 3 | Violated rule while err_o is high, else 0 |
| cmplt_o | output | 1 | One-cycle legal completion pulse |

## Verification
The hardest situations to reach are the edges of the done window: a done in the ignored first gap cycle, a done in the fifth cycle that is still legal, and a timeout in that same cycle. Also hard to reach is a mode change in the middle of a transaction, which must not alter the rules already chosen. Directed sequences place done on each edge of the window and switch mode_i after the request. The random traffic is built as mostly legal transactions with rare faults injected in each phase. Its gap lengths run one past the limit, and mode_i takes an unrelated value on every cycle except the request cycle.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ACK  = 2'd1,
    PH_GAP  = 2'd2,
    PH_DATA = 2'd3
  } phase_e;

  typedef enum logic [2:0] {
    ERR_NONE        = 3'd0,
    ERR_MISS_ACK    = 3'd1,
    ERR_TIMEOUT     = 3'd2,
    ERR_DONE_NOBEAT = 3'd3,
    ERR_BEAT_GAP    = 3'd4,
    ERR_END_NOBEAT  = 3'd5,
    ERR_OVERLAP     = 3'd6
  } err_code_e;

  localparam int CODE_W = $bits(err_code_e);

  // done cycle must carry the first beat
  function automatic logic done_needs_beat(input logic [1:0] m);
    return (m == 2'd1) || (m == 2'd2);
  endfunction

  // end marker must carry the last beat
  function automatic logic end_needs_beat(input logic [1:0] m);
    return (m == 2'd2);
  endfunction

endpackage

// File: rtl/rdseq_gap_timer.sv
module rdseq_gap_timer #(
  parameter int GAP_MIN = 1,
  parameter int GAP_MAX = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic win_open,
  output logic win_last
);
  localparam int CW = $clog2(GAP_MAX + 1);
  localparam logic [CW-1:0] MIN_V = CW'(GAP_MIN);
  localparam logic [CW-1:0] MAX_V = CW'(GAP_MAX);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt != MAX_V) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign win_open = (cnt >= MIN_V);
  assign win_last = (cnt == MAX_V);

  assert_gap_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= MAX_V);

  assert_gap_clear_R3: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0));

endmodule

// File: rtl/rdseq_phase_fsm.sv
module rdseq_phase_fsm
  import rdseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic       ack,
  input  logic       done,
  input  logic       beat,
  input  logic       last,
  input  logic [1:0] mode,
  input  logic       win_open,
  input  logic       win_last,
  output phase_e     phase,
  output logic       ev_err,
  output err_code_e  ev_code,
  output logic       ev_cmp
);
  phase_e     nxt;
  logic [1:0] mode_q;
  logic       need_db;
  logic       need_eb;

  assign need_db = done_needs_beat(mode_q);
  assign need_eb = end_needs_beat(mode_q);

  always_comb begin
    nxt     = phase;
    ev_err  = 1'b0;
    ev_code = ERR_NONE;
    ev_cmp  = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        if (req) nxt = PH_ACK;
      end
      PH_ACK: begin
        if (req) begin
          ev_err = 1'b1; ev_code = ERR_OVERLAP;
        end else if (!ack) begin
          ev_err = 1'b1; ev_code = ERR_MISS_ACK;
        end else begin
          nxt = PH_GAP;
        end
      end
      PH_GAP: begin
        if (req) begin
          ev_err = 1'b1; ev_code = ERR_OVERLAP;
        end else if (done && win_open) begin
          if (need_db && !beat) begin
            ev_err = 1'b1; ev_code = ERR_DONE_NOBEAT;
          end else if (need_eb && last) begin
            ev_cmp = 1'b1;
          end else begin
            nxt = PH_DATA;
          end
        end else if (win_last) begin
          ev_err = 1'b1; ev_code = ERR_TIMEOUT;
        end
      end
      PH_DATA: begin
        if (req) begin
          ev_err = 1'b1; ev_code = ERR_OVERLAP;
        end else if (need_eb) begin
          if (last && beat) begin
            ev_cmp = 1'b1;
          end else if (last) begin
            ev_err = 1'b1; ev_code = ERR_END_NOBEAT;
          end else if (!beat) begin
            ev_err = 1'b1; ev_code = ERR_BEAT_GAP;
          end
        end else begin
          if (last) begin
            ev_cmp = 1'b1;
          end else if (!beat) begin
            ev_err = 1'b1; ev_code = ERR_BEAT_GAP;
          end
        end
      end
      default: nxt = PH_IDLE;
    endcase
    if (ev_err || ev_cmp) nxt = PH_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      mode_q <= 2'd0;
    end else begin
      phase <= nxt;
      if (phase == PH_IDLE && req) mode_q <= mode;
    end
  end

  assert_mode_held_R9: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE) |=> $stable(mode_q));

  assert_ack_entry_R2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && req) |=> (phase == PH_ACK));

endmodule

// File: rtl/rdseq_report.sv
module rdseq_report
  import rdseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_err,
  input  err_code_e         ev_code,
  input  logic              ev_cmp,
  output logic              err_o,
  output logic [CODE_W-1:0] err_code_o,
  output logic              cmplt_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      err_o      <= 1'b0;
      err_code_o <= '0;
      cmplt_o    <= 1'b0;
    end else begin
      err_o      <= ev_err;
      err_code_o <= ev_err ? ev_code : ERR_NONE;
      cmplt_o    <= ev_cmp && !ev_err;
    end
  end

  assert_one_event_R10: assert property (@(posedge clk) disable iff (rst)
    !(err_o && cmplt_o));

  assert_code_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !err_o |-> (err_code_o == '0));

endmodule

// File: rtl/rdseq_checker.sv
module rdseq_checker
  import rdseq_pkg::*;
#(
  parameter int GAP_MIN = 1,
  parameter int GAP_MAX = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic              ack_i,
  input  logic              done_i,
  input  logic              beat_i,
  input  logic              last_i,
  input  logic [1:0]        mode_i,
  output logic              err_o,
  output logic [CODE_W-1:0] err_code_o,
  output logic              cmplt_o
);
  phase_e    phase;
  logic      win_open, win_last;
  logic      ev_err, ev_cmp;
  err_code_e ev_code;

  rdseq_gap_timer #(.GAP_MIN(GAP_MIN), .GAP_MAX(GAP_MAX)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .run      (phase == PH_GAP),
    .win_open (win_open),
    .win_last (win_last)
  );

  rdseq_phase_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .req      (req_i),
    .ack      (ack_i),
    .done     (done_i),
    .beat     (beat_i),
    .last     (last_i),
    .mode     (mode_i),
    .win_open (win_open),
    .win_last (win_last),
    .phase    (phase),
    .ev_err   (ev_err),
    .ev_code  (ev_code),
    .ev_cmp   (ev_cmp)
  );

  rdseq_report u_report (
    .clk        (clk),
    .rst        (rst),
    .ev_err     (ev_err),
    .ev_code    (ev_code),
    .ev_cmp     (ev_cmp),
    .err_o      (err_o),
    .err_code_o (err_code_o),
    .cmplt_o    (cmplt_o)
  );

  assert_miss_ack_R2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ACK && !req_i && !ack_i) |=>
      (err_o && err_code_o == ERR_MISS_ACK));

  assert_overlap_R7: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE && req_i) |=> (err_o && err_code_o == ERR_OVERLAP));

  assert_idle_after_R8: assert property (@(posedge clk) disable iff (rst)
    (err_o || cmplt_o) |-> (phase == PH_IDLE));

  assert_timeout_R3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_GAP && win_last && !done_i && !req_i) |=>
      (err_o && err_code_o == ERR_TIMEOUT));

endmodule

// File: tb/rdseq_checker_bench.sv
`timescale 1ns/1ps
module rdseq_checker_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 0, ack = 0, done = 0, beat = 0, last = 0;
  logic [1:0] mode = 0;
  logic err;
  logic [2:0] code;
  logic cmp;

  always #10 clk = ~clk;

  rdseq_checker u_rdseq_checker (
    .clk(clk), .rst(rst), .req_i(req), .ack_i(ack), .done_i(done),
    .beat_i(beat), .last_i(last), .mode_i(mode),
    .err_o(err), .err_code_o(code), .cmplt_o(cmp)
  );

  int nchk = 0, nbad = 0;
  bit finished = 0;
  // reference model state
  int ms = 0, mc = 0;
  logic [1:0] mm = 0;
  logic exp_err = 0, exp_cmp = 0;
  logic [2:0] exp_code = 0;
  string exp_tag = "R1";

  function automatic logic f_db(input logic [1:0] m); return m == 1 || m == 2; endfunction
  function automatic logic f_eb(input logic [1:0] m); return m == 2; endfunction

  task automatic check();
    nchk++;
    if (err !== exp_err || code !== exp_code || cmp !== exp_cmp) begin
      nbad++;
      $display("FAIL %s: got err=%0b code=%0d cmp=%0b expected err=%0b code=%0d cmp=%0b",
               exp_tag, err, code, cmp, exp_err, exp_code, exp_cmp);
    end
  endtask

  task automatic ev(input int c, input string t);
    exp_err = 1; exp_code = 3'(c); exp_tag = t; ms = 0;
  endtask

  task automatic fin(input string t);
    exp_cmp = 1; exp_tag = (mm == 3) ? "R9" : t; ms = 0;
  endtask

  task automatic model(input logic r, a, d, b, l, input logic [1:0] m);
    exp_err = 0; exp_code = 0; exp_cmp = 0; exp_tag = "R10";
    case (ms)
      0: if (r) begin ms = 1; mm = m; end else exp_tag = "R8";
      1: if (r) ev(6, "R7"); else if (!a) ev(1, "R2"); else begin ms = 2; mc = 0; end
      2: begin
        if (r) ev(6, "R7");
        else if (d && mc >= 1) begin
          if (f_db(mm) && !b) ev(3, "R5");
          else if (f_eb(mm) && l) fin("R6");
          else ms = 3;
        end else if (mc == 4) ev(2, "R3");
        else mc++;
      end
      default: begin
        if (r) ev(6, "R7");
        else if (f_eb(mm)) begin
          if (b && l) fin("R6");
          else if (l) ev(5, "R6");
          else if (!b) ev(4, "R6");
        end else begin
          if (l) fin("R4");
          else if (!b) ev(4, "R4");
        end
      end
    endcase
  endtask

  task automatic step(input logic r, a, d, b, l, input logic [1:0] m);
    @(negedge clk);
    check();
    req = r; ack = a; done = d; beat = b; last = l; mode = m;
    model(r, a, d, b, l, m);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nbad++;
      $display("FAIL watchdog: got hang expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // R1: outputs quiet during reset
    repeat (3) @(negedge clk);
    check();
    rst = 0;
    // R8: noise in idle ignored; R1 first cycle after reset
    step(0, 1, 1, 1, 1, 0);
    step(0, 1, 0, 1, 1, 2);
    idle(2);
    // R4: mode 0, zero beats, done at earliest point
    step(1, 0, 0, 0, 0, 0); step(0, 1, 0, 0, 0, 0); step(0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0); step(0, 0, 0, 0, 1, 0); idle(2);
    // R3: done at latest legal point, then 3 beats (R4)
    step(1, 0, 0, 0, 0, 0); step(0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 1, 1, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 1, 0); idle(2);
    // R3: early done ignored, then timeout
    step(1, 0, 0, 0, 0, 0); step(0, 1, 0, 0, 0, 0); step(0, 0, 1, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0);
    idle(2);
    // R2: missing ack
    step(1, 0, 0, 0, 0, 0); step(0, 0, 1, 1, 0, 0); idle(2);
    // R5: mode 1 done without beat, then legal mode 1
    step(1, 0, 0, 0, 0, 1); step(0, 1, 0, 0, 0, 1); step(0, 0, 0, 0, 0, 1);
    step(0, 0, 1, 0, 0, 1); idle(1);
    step(1, 0, 0, 0, 0, 1); step(0, 1, 0, 0, 0, 1); step(0, 0, 0, 0, 0, 1);
    step(0, 0, 1, 1, 0, 1); step(0, 0, 0, 1, 0, 1); step(0, 0, 0, 0, 1, 1);
    // R8: back-to-back request right after completion
    // R6: mode 2 single-cycle done+beat+end
    step(1, 0, 0, 0, 0, 2); step(0, 1, 0, 0, 0, 2); step(0, 0, 0, 0, 0, 2);
    step(0, 0, 1, 1, 1, 2); idle(1);
    // R6: end without beat
    step(1, 0, 0, 0, 0, 2); step(0, 1, 0, 0, 0, 2); step(0, 0, 0, 0, 0, 2);
    step(0, 0, 1, 1, 0, 2); step(0, 0, 0, 1, 0, 2); step(0, 0, 0, 0, 1, 2); idle(2);
    // R7: overlap in ack cycle and in data phase
    step(1, 0, 0, 0, 0, 0); step(1, 1, 0, 0, 0, 0); idle(2);
    step(1, 0, 0, 0, 0, 0); step(0, 1, 0, 0, 0, 0); step(0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0); step(0, 0, 0, 1, 0, 0); step(1, 0, 0, 1, 0, 0); idle(2);
    // R4: beat gap
    step(1, 0, 0, 0, 0, 0); step(0, 1, 0, 0, 0, 0); step(0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0); step(0, 0, 0, 1, 0, 0); step(0, 0, 0, 0, 0, 0); idle(2);
    // R9: mode captured at request; mode 3 acts as mode 0
    step(1, 0, 0, 0, 0, 2); step(0, 1, 0, 0, 0, 0); step(0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 1, 1, 0); idle(2);
    step(1, 0, 0, 0, 0, 3); step(0, 1, 0, 0, 0, 2); step(0, 0, 0, 0, 0, 1);
    step(0, 0, 1, 0, 0, 2); step(0, 0, 0, 0, 1, 2); idle(2);
    // constrained random transactions
    for (int t = 0; t < 400; t++) begin
      logic [1:0] tm;
      int g, nb;
      tm = 2'($urandom % 4);
      for (int i = 0; i < int'($urandom % 3); i++)
        step(0, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom));
      step(1, 0, 0, 0, 0, tm);
      step(($urandom % 25) == 0, ($urandom % 10) != 0, 1'($urandom), 0, 0, 2'($urandom));
      g = 1 + int'($urandom % 5);
      for (int k = 0; k < g; k++)
        step(($urandom % 60) == 0, 1'($urandom), (k == 0) ? 1'($urandom) : 1'b0,
             1'($urandom), 1'($urandom), 2'($urandom));
      nb = int'($urandom % 4);
      step(0, 0, 1, f_db(tm) ? (($urandom % 10) != 0) : 1'($urandom),
           (nb == 0 && f_eb(tm)) ? 1'b1 : 1'b0, 2'($urandom));
      for (int k = 0; k < nb; k++) begin
        logic lb;
        lb = (k == nb - 1) && f_eb(tm);
        step(($urandom % 60) == 0, 0, 1'($urandom), ($urandom % 12) != 0,
             lb ? 1'b1 : (($urandom % 30) == 0), 2'($urandom));
      end
      if (!f_eb(tm) || nb == 0)
        step(0, 0, 0, ($urandom % 8) == 0 ? 1'b0 : 1'($urandom), ($urandom % 12) != 0, 2'($urandom));
    end
    idle(8);
    @(negedge clk);
    check();
    finished = 1;
    summary();
    $finish;
  end
endmodule